// File: doc/BRIEF.md
# Delay-Slot Exception PC Controller

This block sits in the control path of an in-order pipelined processor whose branches have one architectural delay slot. It watches the retire stream and remembers whether the next instruction to retire sits in the delay slot of a taken branch. While that is so, it records the branch address and the branch target.

Three outputs follow from this tracking. The interrupt-accept output is held low so that an interrupt can never fall between a taken branch and its slot instruction. The PC-relative base output gives the branch target while the slot instruction retires. On a fault, the block saves an exception PC, a delay-slot flag and a cause code.

In the default recoverable mode, a fault in a delay slot saves the address of the branch itself, so a handler can return and run the branch and its slot again. In legacy mode the target address is saved instead. A delay-slot fault saved that way cannot be resumed.

Top module: `dslot_epc_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first fault, `epc_o` reads 0, `epc_in_slot_o` reads 0 and `epc_cause_o` reads 0. After reset no delay slot is pending.
- R2: In a cycle where a taken branch retires (`ret_valid_i`, `ret_branch_i` and `ret_taken_i` all high), `irq_accept_o` is 0 even when `irq_req_i` is 1.
- R3: While a delay slot is pending and no instruction retires, `irq_accept_o` is 0.
- R4: In every other cycle without a fault, `irq_accept_o` equals `irq_req_i`. This includes the cycle in which the slot instruction itself retires.
- R5: A fault (`ret_valid_i` with any fault input high) forces `irq_accept_o` to 0 in that cycle.
- R6: `pcrel_base_o` equals the pending branch's target while a delay slot is pending. Otherwise it equals `ret_pc_i`.
- R7: A fault in an instruction that is not in a delay slot saves `ret_pc_i` into `epc_o` at that clock edge and clears `epc_in_slot_o`.
- R8: With `legacy_mode_i` = 0, a fault in a delay slot saves the address of the taken branch and sets `epc_in_slot_o` to 1.
- R9: With `legacy_mode_i` = 1, a fault in a delay slot saves the branch target and sets `epc_in_slot_o` to 1.
- R10: The instruction after a not-taken branch is an ordinary instruction. A fault in it saves its own address with the flag at 0, and it does not block interrupts.
- R11: A fault clears delay-slot tracking. After a faulting taken branch, the next instruction is not treated as a slot.
- R12: `epc_cause_o` is loaded on a fault with 1 for an illegal opcode, 2 for misalignment and 3 for a translation fault. Illegal opcode has the highest priority and translation fault the lowest. Without a fault, `epc_o`, `epc_in_slot_o` and `epc_cause_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| legacy_mode_i | input | 1 | 1: save the branch target on a delay-slot fault |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_pc_i | input | AW | Address of the retiring instruction |
| ret_branch_i | input | 1 | Retiring instruction is a branch |
| ret_taken_i | input | 1 | The branch is taken |
| ret_target_i | input | AW | Branch target address |
| irq_req_i | input | 1 | Interrupt request |
| flt_illegal_i | input | 1 | Retiring instruction has an illegal opcode |
| flt_align_i | input | 1 | Retiring instruction has an alignment fault |
| flt_xlate_i | input | 1 | Retiring instruction has a translation fault |
| irq_accept_o | output | 1 | The interrupt is taken after this cycle's retire |
| pcrel_base_o | output | AW | Base address for PC-relative operands |
| epc_o | output | AW | Saved exception PC |
| epc_in_slot_o | output | 1 | The saved fault was in a delay slot |
| epc_cause_o | output | 2 | Saved fault cause |

## Verification
The assertions check on every cycle that:
- an interrupt is never accepted on a taken-branch retire or in a fault cycle;
- the PC-relative base follows the retire address when no slot is pending;
- the saved registers hold between faults;
- tracking is clear after a fault.

Only the bench scenarios can show the following, because they depend on which fault sequence came before:
- which address is saved in each mode;
- the behaviour after a not-taken branch;
- the cause priority when several fault inputs are high together.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_ILLEGAL = 2'd1,
    CAUSE_ALIGN   = 2'd2,
    CAUSE_XLATE   = 2'd3
  } cause_e;
endpackage

// File: rtl/dslot_tracker.sv
module dslot_tracker #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ret_valid_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic          ret_branch_i,
  input  logic          ret_taken_i,
  input  logic [AW-1:0] ret_target_i,
  input  logic          fault_i,
  output logic          in_slot_o,
  output logic [AW-1:0] br_pc_o,
  output logic [AW-1:0] br_tgt_o
);
  logic          slot_q;
  logic [AW-1:0] pc_q, tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      pc_q   <= '0;
      tgt_q  <= '0;
    end else if (fault_i) begin
      slot_q <= 1'b0;
    end else if (ret_valid_i) begin
      slot_q <= ret_branch_i & ret_taken_i;
      if (ret_branch_i & ret_taken_i) begin
        pc_q  <= ret_pc_i;
        tgt_q <= ret_target_i;
      end
    end
  end

  assign in_slot_o = slot_q;
  assign br_pc_o   = pc_q;
  assign br_tgt_o  = tgt_q;

  AST_SLOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !in_slot_o); // R11
endmodule

// File: rtl/dslot_irq_gate.sv
module dslot_irq_gate (
  input  logic ret_valid_i,
  input  logic taken_br_i,
  input  logic in_slot_i,
  input  logic fault_i,
  input  logic irq_req_i,
  output logic irq_accept_o
);
  logic shield;

  // no interrupt between a taken branch and its slot instruction
  always_comb begin
    shield = (ret_valid_i & taken_br_i) | (~ret_valid_i & in_slot_i);
    irq_accept_o = irq_req_i & ~fault_i & ~shield;
  end
endmodule

// File: rtl/dslot_epc_reg.sv
module dslot_epc_reg
  import dslot_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          legacy_mode_i,
  input  logic          fault_i,
  input  logic          in_slot_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic [AW-1:0] br_pc_i,
  input  logic [AW-1:0] br_tgt_i,
  input  logic          flt_illegal_i,
  input  logic          flt_align_i,
  input  logic          flt_xlate_i,
  output logic [AW-1:0] epc_o,
  output logic          in_slot_o,
  output cause_e        cause_o
);
  logic [AW-1:0] epc_d;
  cause_e        cause_d;

  always_comb begin
    if (!in_slot_i)         epc_d = ret_pc_i;
    else if (legacy_mode_i) epc_d = br_tgt_i;
    else                    epc_d = br_pc_i;
    if (flt_illegal_i)      cause_d = CAUSE_ILLEGAL;
    else if (flt_align_i)   cause_d = CAUSE_ALIGN;
    else if (flt_xlate_i)   cause_d = CAUSE_XLATE;
    else                    cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o     <= '0;
      in_slot_o <= 1'b0;
      cause_o   <= CAUSE_NONE;
    end else if (fault_i) begin
      epc_o     <= epc_d;
      in_slot_o <= in_slot_i;
      cause_o   <= cause_d;
    end
  end

  AST_EPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i |=> $stable(epc_o) && $stable(in_slot_o) && $stable(cause_o)); // R12
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !in_slot_i |=> !in_slot_o && epc_o == $past(ret_pc_i)); // R7
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> cause_o != CAUSE_NONE); // R12
endmodule

// File: rtl/dslot_epc_ctrl.sv
module dslot_epc_ctrl
  import dslot_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          legacy_mode_i,
  input  logic          ret_valid_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic          ret_branch_i,
  input  logic          ret_taken_i,
  input  logic [AW-1:0] ret_target_i,
  input  logic          irq_req_i,
  input  logic          flt_illegal_i,
  input  logic          flt_align_i,
  input  logic          flt_xlate_i,
  output logic          irq_accept_o,
  output logic [AW-1:0] pcrel_base_o,
  output logic [AW-1:0] epc_o,
  output logic          epc_in_slot_o,
  output logic [1:0]    epc_cause_o
);
  logic          fault, in_slot;
  logic [AW-1:0] br_pc, br_tgt;
  cause_e        cause;

  assign fault = ret_valid_i & (flt_illegal_i | flt_align_i | flt_xlate_i);

  dslot_tracker #(.AW(AW)) u_track (
    .clk_i, .rst_ni, .ret_valid_i, .ret_pc_i, .ret_branch_i, .ret_taken_i,
    .ret_target_i, .fault_i(fault), .in_slot_o(in_slot),
    .br_pc_o(br_pc), .br_tgt_o(br_tgt)
  );

  dslot_irq_gate u_gate (
    .ret_valid_i, .taken_br_i(ret_branch_i & ret_taken_i), .in_slot_i(in_slot),
    .fault_i(fault), .irq_req_i, .irq_accept_o
  );

  dslot_epc_reg #(.AW(AW)) u_epc (
    .clk_i, .rst_ni, .legacy_mode_i, .fault_i(fault), .in_slot_i(in_slot),
    .ret_pc_i, .br_pc_i(br_pc), .br_tgt_i(br_tgt), .flt_illegal_i,
    .flt_align_i, .flt_xlate_i, .epc_o, .in_slot_o(epc_in_slot_o), .cause_o(cause)
  );

  assign pcrel_base_o = in_slot ? br_tgt : ret_pc_i;
  assign epc_cause_o  = cause;

  AST_NO_IRQ_ON_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_branch_i && ret_taken_i |-> !irq_accept_o); // R2
  AST_NO_IRQ_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && (flt_illegal_i || flt_align_i || flt_xlate_i) |-> !irq_accept_o); // R5
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_accept_o |-> irq_req_i); // R4
  AST_PCREL_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_slot |-> pcrel_base_o == ret_pc_i); // R6
  AST_SLOT_AFTER_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_branch_i && ret_taken_i && !fault |=> in_slot); // R6
endmodule

// File: tb/dslot_epc_ctrl_bench.sv
`timescale 1ns/1ps
module dslot_epc_ctrl_bench;
  localparam int AW = 32;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic legacy, v, br, tk, irq, fi, fa, fx;
  logic [AW-1:0] pc, tgt;
  logic irq_acc, slot_o;
  logic [AW-1:0] pcrel, epc;
  logic [1:0] cause;
  int errors = 0, checks = 0;

  // reference state
  bit m_slot;
  logic [AW-1:0] m_bpc, m_btgt, m_epc;
  bit m_flag;
  int m_cause;

  always #2.5 clk = ~clk;

  dslot_epc_ctrl #(.AW(AW)) u_dslot_epc_ctrl (
    .clk_i(clk), .rst_ni, .legacy_mode_i(legacy), .ret_valid_i(v), .ret_pc_i(pc),
    .ret_branch_i(br), .ret_taken_i(tk), .ret_target_i(tgt), .irq_req_i(irq),
    .flt_illegal_i(fi), .flt_align_i(fa), .flt_xlate_i(fx),
    .irq_accept_o(irq_acc), .pcrel_base_o(pcrel), .epc_o(epc),
    .epc_in_slot_o(slot_o), .epc_cause_o(cause)
  );

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit iv, logic [AW-1:0] ipc, bit ibr, bit itk,
                      logic [AW-1:0] itgt, bit iirq, bit ifi, bit ifa, bit ifx, bit ileg);
    bit f, e_acc;
    logic [AW-1:0] e_pcrel;
    @(negedge clk);
    v = iv; pc = ipc; br = ibr; tk = itk; tgt = itgt; irq = iirq;
    fi = ifi; fa = ifa; fx = ifx; legacy = ileg;
    f = iv && (ifi || ifa || ifx);
    if (f) e_acc = 0;
    else if (iv && ibr && itk) e_acc = 0;
    else if (!iv && m_slot) e_acc = 0;
    else e_acc = iirq;
    e_pcrel = m_slot ? m_btgt : ipc;
    #1;
    chk(req, "irq_accept", AW'(irq_acc), AW'(e_acc));
    chk(req, "pcrel_base", pcrel, e_pcrel);
    @(posedge clk);
    if (f) begin
      m_epc  = !m_slot ? ipc : (ileg ? m_btgt : m_bpc);
      m_flag = m_slot;
      m_cause = ifi ? 1 : (ifa ? 2 : 3);
      m_slot = 0;
    end else if (iv) begin
      m_slot = ibr && itk;
      if (ibr && itk) begin m_bpc = ipc; m_btgt = itgt; end
    end
    #1;
    chk(req, "epc", epc, m_epc);
    chk(req, "epc_in_slot", AW'(slot_o), AW'(m_flag));
    chk(req, "cause", AW'(cause), AW'(m_cause));
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    legacy = 0; v = 0; br = 0; tk = 0; irq = 0; fi = 0; fa = 0; fx = 0;
    pc = '0; tgt = '0;
    m_slot = 0; m_bpc = '0; m_btgt = '0; m_epc = '0; m_flag = 0; m_cause = 0;
    #12;
    chk("R1", "epc in reset", epc, '0);
    chk("R1", "flag in reset", AW'(slot_o), '0);
    chk("R1", "cause in reset", AW'(cause), '0);
    @(negedge clk); rst_ni = 1'b1;
    // R4 plain retire with irq
    step("R4", 1, 32'h100, 0, 0, 0, 1, 0, 0, 0, 0);
    // R2 taken branch blocks irq, R3 bubble in slot blocks, R6 slot base
    step("R2", 1, 32'h104, 1, 1, 32'h400, 1, 0, 0, 0, 0);
    step("R3", 0, 32'h0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R6", 1, 32'h108, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R6", 1, 32'h400, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 ordinary fault
    step("R7", 1, 32'h404, 0, 0, 0, 1, 0, 1, 0, 0);
    // R8 recoverable slot fault
    step("R2", 1, 32'h408, 1, 1, 32'h800, 0, 0, 0, 0, 0);
    step("R8", 1, 32'h40c, 0, 0, 0, 1, 0, 0, 1, 0);
    // R11 tracking cleared after fault
    step("R11", 1, 32'h900, 0, 0, 0, 1, 0, 0, 0, 0);
    // R9 legacy slot fault
    step("R2", 1, 32'h904, 1, 1, 32'hA00, 0, 0, 0, 0, 1);
    step("R9", 1, 32'h908, 0, 0, 0, 0, 1, 0, 0, 1);
    // R10 not-taken branch
    step("R10", 1, 32'hA00, 1, 0, 32'hC00, 1, 0, 0, 0, 0);
    step("R10", 1, 32'hA04, 0, 0, 0, 0, 0, 1, 0, 0);
    // R11 fault on a taken branch cancels slot tracking
    step("R11", 1, 32'hB00, 1, 1, 32'hD00, 0, 0, 0, 1, 0);
    step("R11", 0, 32'h0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R11", 1, 32'hB04, 0, 0, 0, 0, 0, 1, 0, 0);
    // R12 priority and hold
    step("R12", 1, 32'hC00, 0, 0, 0, 0, 1, 1, 1, 0);
    step("R12", 1, 32'hC04, 0, 0, 0, 0, 0, 1, 1, 0);
    step("R12", 1, 32'hC08, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R12", 0, 32'hC0C, 0, 0, 0, 0, 1, 1, 1, 0);
    // R5 fault beats irq in a slot, legacy off
    step("R2", 1, 32'hE00, 1, 1, 32'hF00, 1, 0, 0, 0, 0);
    step("R5", 1, 32'hE04, 0, 0, 0, 1, 1, 0, 0, 0);
    step("R4", 0, 32'h0, 0, 0, 0, 1, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule